// File: doc/BRIEF.md
# Three-Lane Multi-Format Serial Audio Receiver

The block deserialises PCM audio arriving on three serial data lines. All three lines are timed by one shared bit clock and one shared frame clock. The frame clock runs at the sample rate, and its two levels mark the left and right half-frames. The block runs directly on the bit clock and samples the frame clock and all three data lines on each rising edge. Each frame yields one left and one right word per lane, which gives six words per frame.

Two static configuration inputs select the framing and the word length. Three framings are supported. In left-justified framing, the MSB is the first bit of a half-frame. In I2S framing, the MSB comes one bit clock after the frame edge. In right-justified framing, the LSB is the last bit before the next frame edge. Each captured word is MSB-first and is sign-extended to 32 bits. After the right half of a frame has closed, all six output words change in the same cycle, and a one-cycle strobe marks that cycle.

Top module: `tri_lane_audio_rx`

## Requirements
- R1: While `rst` is high at a rising edge, `pcm_valid` is cleared to 0 and all six output words are cleared to zero.
- R2: `frame_fmt` codes are 0 for left-justified, 1 for I2S and 2 for right-justified. Code 3 behaves exactly like code 0. `word_len` codes 0, 1, 2 and 3 select 16, 20, 24 and 32 bits.
- R3: In left-justified framing, `frame_clk` low marks the left half. The bit sampled on the first rising edge of a half is the MSB. Bits after the selected word length are ignored.
- R4: In I2S framing, `frame_clk` low marks the left half. The MSB is the bit sampled on the second rising edge of a half. The bit on the first edge is ignored, and so are bits after the word.
- R5: In right-justified framing, `frame_clk` high marks the left half. The LSB is the last bit sampled before `frame_clk` changes. Earlier bits in that half are ignored. The half may be exactly the word length or longer.
- R6: Every output word is the captured word sign-extended from its MSB to 32 bits.
- R7: The three lanes are captured in lockstep. Each lane's words depend only on its own data bit, `sd_in[i]`.
- R8: `pcm_valid` is high for exactly one cycle. That cycle follows the rising edge at which `frame_clk` is first sampled at its left-half level after a right half. It happens once per complete frame.
- R9: The six output words change only in the cycle in which `pcm_valid` is high, and they hold their values between pulses.
- R10: After reset, nothing is captured until `frame_clk` has been seen to change. A right half that follows no left half completed since reset or since the last pulse produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_fmt | input | 2 | Framing select (0 left-justified, 1 I2S, 2 right-justified, 3 as 0) |
| word_len | input | 2 | Word length select (16/20/24/32 bits) |
| frame_clk | input | 1 | Left/right frame clock shared by all lanes |
| sd_in | input | 3 | Serial data, one bit per lane |
| pcm_left | output | 3x32 | Sign-extended left words, lane i in bits [32i+31:32i] |
| pcm_right | output | 3x32 | Sign-extended right words, lane i in bits [32i+31:32i] |
| pcm_valid | output | 1 | One-cycle strobe when all six words update |

## Verification
The sweep covers every framing code (including the alias code 3) and every word length. Each combination runs once with the shortest legal half-frame and once with 40-bit half-frames that carry random filler bits. A receiver with an off-by-one bit alignment, or one that reads the filler as data, returns shifted or corrupted words. The test words include the most negative value, the most positive value, minus one, zero and one on different lanes, so a wrong sign-extension point or a swapped lane shows up at once. Each run opens with a stray right half before the first left half; a receiver that does not wait for a complete left-then-right pair emits an extra strobe.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int SAMPLE_W = 32;

    typedef enum logic [1:0] {
        FMT_LJ  = 2'd0,
        FMT_I2S = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_LJ2 = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        WL16 = 2'd0,
        WL20 = 2'd1,
        WL24 = 2'd2,
        WL32 = 2'd3
    } wl_e;

    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_HUNT  = 2'd1,
        ST_RUN   = 2'd2
    } sync_e;

    // per-cycle control shared by every lane
    typedef struct packed {
        logic take;       // current bit belongs to the word
        logic restart;    // frame edge: shift register starts over
        logic close;      // a complete half-frame ended before this bit
        logic close_left; // the half that ended was the left one
    } slot_ctl_t;

    function automatic logic [5:0] word_bits(input wl_e w);
        case (w)
            WL16:    return 6'd16;
            WL20:    return 6'd20;
            WL24:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [SAMPLE_W-1:0] sign_fill(input logic [SAMPLE_W-1:0] v,
                                                       input wl_e w);
        logic signed [SAMPLE_W-1:0] t;
        logic [5:0]                 sh;
        sh = 6'd32 - word_bits(w);
        t  = signed'(v << sh);
        return unsigned'(t >>> sh);
    endfunction

    function automatic logic left_level(input fmt_e f);
        return (f == FMT_RJ);
    endfunction

endpackage

// File: rtl/arx_slot_timer.sv
module arx_slot_timer
    import arx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  fmt_e      fmt,
    input  wl_e       wl,
    input  logic      lr,
    output slot_ctl_t ctl
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    sync_e            state;
    logic             lr_q;
    logic [CNT_W-1:0] cnt;
    logic             edge_seen;
    logic [CNT_W-1:0] idx;
    int unsigned      lo;
    int unsigned      hi;

    assign edge_seen = (state != ST_PRIME) && (lr != lr_q);
    assign idx       = edge_seen ? '0 : cnt;

    always_comb begin
        lo = (fmt == FMT_I2S) ? 1 : 0;
        hi = lo + int'(word_bits(wl));
        ctl.take       = (fmt == FMT_RJ) ||
                         ((int'(idx) >= lo) && (int'(idx) < hi));
        ctl.restart    = edge_seen;
        ctl.close      = edge_seen && (state == ST_RUN);
        ctl.close_left = (lr_q == left_level(fmt));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PRIME;
            lr_q  <= 1'b0;
            cnt   <= '0;
        end else begin
            lr_q <= lr;
            case (state)
                ST_PRIME: state <= ST_HUNT;
                ST_HUNT: begin
                    if (edge_seen) begin
                        state <= ST_RUN;
                        cnt   <= CNT_W'(1);
                    end
                end
                default: begin
                    if (edge_seen)
                        cnt <= CNT_W'(1);
                    else if (cnt != CNT_MAX)
                        cnt <= cnt + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/arx_lane_shifter.sv
module arx_lane_shifter
    import arx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  slot_ctl_t           ctl,
    input  logic                din,
    output logic [SAMPLE_W-1:0] word
);
    logic [SAMPLE_W-1:0] sh;

    assign word = sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (ctl.restart)
            sh <= ctl.take ? {{(SAMPLE_W-1){1'b0}}, din} : '0;
        else if (ctl.take)
            sh <= {sh[SAMPLE_W-2:0], din};
    end
endmodule

// File: rtl/arx_frame_assembler.sv
module arx_frame_assembler
    import arx_pkg::*;
#(
    parameter int NLANE = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  slot_ctl_t                       ctl,
    input  wl_e                             wl,
    input  logic [NLANE-1:0][SAMPLE_W-1:0]  words,
    output logic [NLANE-1:0][SAMPLE_W-1:0]  left_o,
    output logic [NLANE-1:0][SAMPLE_W-1:0]  right_o,
    output logic                            valid_o
);
    logic [NLANE-1:0][SAMPLE_W-1:0] hold_l;
    logic                           left_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l  <= '0;
            left_ok <= 1'b0;
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (ctl.close) begin
                if (ctl.close_left) begin
                    for (int i = 0; i < NLANE; i++)
                        hold_l[i] <= sign_fill(words[i], wl);
                    left_ok <= 1'b1;
                end else begin
                    left_ok <= 1'b0;
                    if (left_ok) begin
                        for (int i = 0; i < NLANE; i++)
                            right_o[i] <= sign_fill(words[i], wl);
                        left_o  <= hold_l;
                        valid_o <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tri_lane_audio_rx.sv
module tri_lane_audio_rx
    import arx_pkg::*;
#(
    parameter int NLANE = 3,
    parameter int CNT_W = 6
) (
    input  logic                            bit_clk,
    input  logic                            rst,
    input  logic [1:0]                      frame_fmt,
    input  logic [1:0]                      word_len,
    input  logic                            frame_clk,
    input  logic [NLANE-1:0]                sd_in,
    output logic [NLANE-1:0][SAMPLE_W-1:0]  pcm_left,
    output logic [NLANE-1:0][SAMPLE_W-1:0]  pcm_right,
    output logic                            pcm_valid
);
    slot_ctl_t                      ctl;
    logic [NLANE-1:0][SAMPLE_W-1:0] lane_word;
    fmt_e                           fmt;
    wl_e                            wl;

    assign fmt = fmt_e'(frame_fmt);
    assign wl  = wl_e'(word_len);

    arx_slot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (bit_clk),
        .rst (rst),
        .fmt (fmt),
        .wl  (wl),
        .lr  (frame_clk),
        .ctl (ctl)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        arx_lane_shifter u_shift (
            .clk  (bit_clk),
            .rst  (rst),
            .ctl  (ctl),
            .din  (sd_in[g]),
            .word (lane_word[g])
        );
    end

    arx_frame_assembler #(.NLANE(NLANE)) u_asm (
        .clk     (bit_clk),
        .rst     (rst),
        .ctl     (ctl),
        .wl      (wl),
        .words   (lane_word),
        .left_o  (pcm_left),
        .right_o (pcm_right),
        .valid_o (pcm_valid)
    );
endmodule

// File: rtl/tri_lane_audio_rx_chk.sv
module tri_lane_audio_rx_chk #(
    parameter int NLANE = 3
) (
    input logic                    bit_clk,
    input logic                    rst,
    input logic [1:0]              frame_fmt,
    input logic [1:0]              word_len,
    input logic                    frame_clk,
    input logic [NLANE-1:0][31:0]  pcm_left,
    input logic [NLANE-1:0][31:0]  pcm_right,
    input logic                    pcm_valid
);
    function automatic logic top_same(input logic [31:0] x, input logic [1:0] w);
        case (w)
            2'd0:    return (&x[31:15]) | ~(|x[31:15]);
            2'd1:    return (&x[31:19]) | ~(|x[31:19]);
            2'd2:    return (&x[31:23]) | ~(|x[31:23]);
            default: return 1'b1;
        endcase
    endfunction

    logic ext_ok;
    always_comb begin
        ext_ok = 1'b1;
        for (int i = 0; i < NLANE; i++)
            ext_ok = ext_ok & top_same(pcm_left[i], word_len)
                            & top_same(pcm_right[i], word_len);
    end

    // R8
    single_pulse_chk: assert property (@(posedge bit_clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);

    // R8
    left_edge_pulse_chk: assert property (@(posedge bit_clk) disable iff (rst)
        pcm_valid |-> ($past(frame_clk) != $past(frame_clk, 2)) &&
                      ($past(frame_clk) == (frame_fmt == 2'd2)));

    // R9
    words_hold_chk: assert property (@(posedge bit_clk) disable iff (rst)
        !pcm_valid |-> ($stable(pcm_left) && $stable(pcm_right)));

    // R6
    sign_extend_chk: assert property (@(posedge bit_clk) disable iff (rst)
        pcm_valid |-> ext_ok);
endmodule

bind tri_lane_audio_rx tri_lane_audio_rx_chk #(.NLANE(NLANE)) u_chk (
    .bit_clk   (bit_clk),
    .rst       (rst),
    .frame_fmt (frame_fmt),
    .word_len  (word_len),
    .frame_clk (frame_clk),
    .pcm_left  (pcm_left),
    .pcm_right (pcm_right),
    .pcm_valid (pcm_valid)
);

// File: tb/sim_tri_lane_audio_rx.sv
module sim_tri_lane_audio_rx;
    localparam int NF = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       fmt = 2'd0;
    logic [1:0]       wl  = 2'd0;
    logic             lr  = 1'b0;
    logic [2:0]       sd  = 3'd0;
    logic [2:0][31:0] pl, pr;
    logic             pv;

    always #10 clk = ~clk;

    tri_lane_audio_rx u0 (
        .bit_clk(clk), .rst(rst), .frame_fmt(fmt), .word_len(wl),
        .frame_clk(lr), .sd_in(sd), .pcm_left(pl), .pcm_right(pr), .pcm_valid(pv)
    );

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;
    logic [31:0] raw_l [NF][3];
    logic [31:0] raw_r [NF][3];
    logic [31:0] exp_l [NF][3];
    logic [31:0] exp_r [NF][3];
    int n_pulse;
    bit mon_en = 0;
    bit prev_v = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s fmt=%0d wl=%0d actual=%h expected=%h", req, fmt, wl, act, expv);
        end
    endtask

    function automatic int wbits(input logic [1:0] c);
        case (c)
            2'd0: return 16;
            2'd1: return 20;
            2'd2: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] sext(input logic [31:0] raw, input int wb);
        logic [63:0] m;
        m = (64'd1 << wb) - 64'd1;
        return raw[wb-1] ? (raw | ~m[31:0]) : (raw & m[31:0]);
    endfunction

    // R6 R7 R8 R9 R10: pulse-time comparison of all six words
    always @(negedge clk) begin
        if (mon_en) begin
            if (pv) begin
                chk(!prev_v, "R8 pulse wider than one cycle", 32'(pv), 32'd0);
                if (n_pulse < NF) begin
                    for (int i = 0; i < 3; i++) begin
                        chk(pl[i] == exp_l[n_pulse][i], "R3/R4/R5/R6/R7 left word", pl[i], exp_l[n_pulse][i]);
                        chk(pr[i] == exp_r[n_pulse][i], "R3/R4/R5/R6/R7 right word", pr[i], exp_r[n_pulse][i]);
                    end
                end else begin
                    chk(1'b0, "R10 unexpected pulse", 32'(n_pulse), 32'(NF));
                end
                n_pulse++;
            end
            prev_v = pv;
        end
    end

    task automatic drive_bit(input logic l, input logic [2:0] d);
        @(negedge clk);
        lr = l;
        sd = d;
    endtask

    task automatic send_half(input int f, input bit is_left, input logic l, input int sl);
        int wb;
        wb = wbits(wl);
        for (int i = 0; i < sl; i++) begin
            logic [2:0] d;
            for (int ln = 0; ln < 3; ln++) begin
                logic [31:0] w;
                int k;
                w = is_left ? raw_l[f][ln] : raw_r[f][ln];
                k = -1;
                if (fmt == 2'd1) begin
                    if (i >= 1 && i <= wb) k = i - 1;
                end else if (fmt == 2'd2) begin
                    if (i >= sl - wb) k = i - (sl - wb);
                end else begin
                    if (i < wb) k = i;
                end
                d[ln] = (k >= 0) ? w[wb-1-k] : 1'($urandom % 2);
            end
            drive_bit(l, d);
        end
    endtask

    task automatic run_cfg(input logic [1:0] f, input logic [1:0] w, input int sl);
        logic left_lv;
        int wb;
        @(negedge clk);
        rst = 1'b1;
        fmt = f;
        wl  = w;
        left_lv = (f == 2'd2);
        lr = left_lv;
        sd = 3'd0;
        repeat (2) @(negedge clk);
        // R1: cleared state after reset
        chk(pv == 1'b0, "R1 valid after reset", 32'(pv), 32'd0);
        for (int i = 0; i < 3; i++) begin
            chk(pl[i] == 32'd0, "R1 left after reset", pl[i], 32'd0);
            chk(pr[i] == 32'd0, "R1 right after reset", pr[i], 32'd0);
        end
        rst = 1'b0;
        n_pulse = 0;
        prev_v  = 0;
        mon_en  = 1;
        wb = wbits(w);
        // R10: level seen at start, then a stray right half
        repeat (3) drive_bit(left_lv, 3'b111);
        repeat (8) drive_bit(!left_lv, 3'($urandom));
        for (int fr = 0; fr < NF; fr++) begin
            for (int ln = 0; ln < 3; ln++) begin
                logic [31:0] a, b;
                a = $urandom;
                b = $urandom;
                if (fr == 0) begin
                    a = (ln == 0) ? (32'd1 << (wb - 1)) :
                        (ln == 1) ? ((32'd1 << (wb - 1)) - 32'd1) : 32'hFFFF_FFFF;
                    b = (ln == 0) ? 32'd0 : (ln == 1) ? 32'd1 : (32'd1 << (wb - 1));
                end
                raw_l[fr][ln] = a;
                raw_r[fr][ln] = b;
                exp_l[fr][ln] = sext(a, wb);
                exp_r[fr][ln] = sext(b, wb);
            end
            send_half(fr, 1'b1, left_lv, sl);
            send_half(fr, 1'b0, !left_lv, sl);
        end
        repeat (4) drive_bit(left_lv, 3'($urandom));
        @(posedge clk);
        mon_en = 0;
        // R8 R10: exactly one pulse per complete frame
        chk(n_pulse == NF, "R8/R10 pulse count", 32'(n_pulse), 32'(NF));
    endtask

    initial begin
        for (int f = 0; f < 4; f++) begin
            for (int w = 0; w < 4; w++) begin
                int wb;
                wb = wbits(2'(w));
                // R2 R5: shortest legal half-frame, then a padded one
                run_cfg(2'(f), 2'(w), (f == 1) ? wb + 1 : wb);
                run_cfg(2'(f), 2'(w), 40);
            end
        end
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
        $finish;
    end
endmodule